// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps a small direct-mapped cache coherent with its peers on a shared snooping bus. Each line holds one data word, an address tag and one of four coherency states: Invalid, Shared, Exclusive or Modified. A local core issues reads and writes through a request/ready port. The controller answers hits at once. For misses, upgrades and dirty evictions it requests the bus through a single grant input. At the same time it watches reads and read-exclusive requests from other masters on the bus. To those it answers with a shared indication and, when it holds the only up-to-date copy, a write-back of the word.

The line index is the low `IDXW` bits of the address and the tag is the rest. The core holds its request fields steady until it sees `cpu_ready`. A bus transaction is placed on the bus in the cycle where `bus_gnt` is high while `bus_req` is high. For a read or read-exclusive, the fill word and the other caches' shared indication are taken exactly one cycle later. No snoop arrives in that fill cycle, because the bus is busy with this cache's transfer.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready`, `bus_req`, `snp_hit` and `snp_wb` are low. Whenever `bus_req` is low, `bus_cmd` is 0.
- R2: A core read to an Invalid line puts a bus read (`bus_cmd`=1) on the bus with the request address. One cycle after the grant the controller samples `bus_shared`. It installs the line as Shared if that input is 1 and as Exclusive if it is 0, and it returns the fill word on `cpu_rdata`.
- R3: A core read that hits a Shared, Exclusive or Modified line raises no bus request. It returns the stored word with `cpu_ready` one cycle after the request is accepted, and `cpu_ready` is a single-cycle pulse.
- R4: A core write to an Invalid line issues a read-exclusive (`bus_cmd`=2). It then installs the line as Modified, holding the written word.
- R5: A core write to a Shared line issues an upgrade (`bus_cmd`=3). Once granted, the line becomes Modified with the written word and no fill cycle occurs.
- R6: A core write to an Exclusive or Modified line raises no bus request and leaves the line Modified with the new word.
- R7: A snooped read (`snp_excl`=0) that hits an Exclusive or Shared line raises `snp_hit` and leaves the line Shared, with no write-back. A snoop whose tag does not match a valid line raises neither output.
- R8: A snooped read that hits a Modified line raises both `snp_hit` and `snp_wb`. It writes back the word and its address on `snp_wb_data` and `snp_wb_addr`, and leaves the line Shared.
- R9: A snooped read-exclusive (`snp_excl`=1) leaves a hit line Invalid and never raises `snp_hit`. A Modified line is written back through `snp_wb`; an Exclusive or Shared line is dropped silently.
- R10: A miss that lands on a Modified line with another tag first writes that line back (`bus_cmd`=4, victim address, victim word on `bus_wdata`) and then issues its own request. A clean victim is replaced without a write-back.
- R11: If a snoop arrives while a request waits for grant, the snoop is serviced first. A grant in that same cycle is ignored, `bus_req` drops the next cycle, and the hit/miss decision is taken again from the updated line state.
- R12: A snoop in the same cycle as a new core request is handled first, and the request completes after it. Snoop responses appear the cycle after the snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Core request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write-back word |
| bus_rdata | input | DW | Fill word, one cycle after grant |
| bus_shared | input | 1 | Shared indication from other caches, one cycle after grant |
| snp_valid | input | 1 | Snooped transaction from another master |
| snp_excl | input | 1 | 1 = read-exclusive, 0 = read |
| snp_addr | input | AW | Snooped address |
| snp_hit | output | 1 | Shared indication driven to the bus |
| snp_wb | output | 1 | Snoop write-back valid |
| snp_wb_addr | output | AW | Snoop write-back address |
| snp_wb_data | output | DW | Snoop write-back word |

## Verification
A snoop and a local grant can fall in the same cycle. So can a snoop and a fresh core request. The bench provokes the first by raising `bus_gnt` and a read-exclusive snoop to the same line in the cycle where an upgrade is pending. It then expects no write-back, a dropped request and a new read-exclusive, and the written word must read back afterwards. For the second it raises a core read and a snooped read together. It expects the snoop's shared answer in the next cycle, a delayed `cpu_ready`, and no bus traffic from the read.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPG  = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_t;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_RESP = 2'd2,
    F_DONE = 2'd3
  } fsm_t;
endpackage

// File: rtl/mesi_tag_state.sv
module mesi_tag_state
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TW    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(LINES)-1:0] a_idx,
  input  logic [$clog2(LINES)-1:0] b_idx,
  input  logic                     we,
  input  logic [$clog2(LINES)-1:0] w_idx,
  input  line_st_t                 w_st,
  input  logic                     tag_we,
  input  logic [TW-1:0]            w_tag,
  output line_st_t                 a_st,
  output logic [TW-1:0]            a_tag,
  output line_st_t                 b_st,
  output logic [TW-1:0]            b_tag
);
  line_st_t      st_q  [LINES];
  logic [TW-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (we) begin
      st_q[w_idx] <= w_st;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[w_idx] <= w_tag;
  end

  assign a_st  = st_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_tag = tag_q[b_idx];

  // R4/R2: a tag is only written together with a state write
  a_r2_tag_with_state: assert property (@(posedge clk) disable iff (rst)
    tag_we |-> we);
endmodule

// File: rtl/mesi_data_ram.sv
module mesi_data_ram #(
  parameter int LINES = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(LINES)-1:0] w_idx,
  input  logic [DW-1:0]            w_data,
  input  logic [$clog2(LINES)-1:0] a_idx,
  output logic [DW-1:0]            a_data,
  input  logic [$clog2(LINES)-1:0] b_idx,
  output logic [DW-1:0]            b_data
);
  logic [DW-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_data;
  end

  assign a_data = mem[a_idx];
  assign b_data = mem[b_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snp_valid,
  input  logic          snp_excl,
  input  logic [AW-1:0] snp_addr,
  input  logic          line_match,
  input  line_st_t      line_st,
  input  logic [DW-1:0] line_data,
  output logic          upd,
  output line_st_t      new_st,
  output logic          hit_o,
  output logic          wb_o,
  output logic [AW-1:0] wb_addr_o,
  output logic [DW-1:0] wb_data_o
);
  always_comb begin
    upd    = snp_valid && line_match;
    new_st = snp_excl ? ST_I : ST_S;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o     <= 1'b0;
      wb_o      <= 1'b0;
      wb_addr_o <= '0;
      wb_data_o <= '0;
    end else begin
      hit_o     <= snp_valid && line_match && !snp_excl;
      wb_o      <= snp_valid && line_match && (line_st == ST_M);
      wb_addr_o <= snp_addr;
      wb_data_o <= line_data;
    end
  end

  // R7: the shared answer only follows a snooped read
  a_r7_hit_after_read: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(snp_valid && !snp_excl));
  // R8: a write-back only follows a snoop
  a_r8_wb_after_snoop: assert property (@(posedge clk) disable iff (rst)
    wb_o |-> $past(snp_valid));
  // R9: no shared answer to a read-exclusive
  a_r9_no_hit_on_excl: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_excl) |=> !hit_o);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [2:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic          snp_excl,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_hit,
  output logic          snp_wb,
  output logic [AW-1:0] snp_wb_addr,
  output logic [DW-1:0] snp_wb_data
);
  localparam int IDXW = $clog2(LINES);
  localparam int TW   = AW - IDXW;

  logic [IDXW-1:0] c_idx, s_idx, arr_idx;
  logic [TW-1:0]   c_tag, s_tag, a_tag, b_tag;
  line_st_t        a_st, b_st, loc_st, snp_new_st, arr_st;
  logic [DW-1:0]   a_data, b_data, dat_wd;
  logic            c_hit, s_hit, loc_we, tag_we, dat_we, snp_upd, arr_we;

  fsm_t            fsm_q, nxt_fsm;
  bus_cmd_t        cmd_q, nxt_cmd;
  logic [AW-1:0]   baddr_q, nxt_baddr;
  logic [DW-1:0]   bwdata_q, nxt_bwdata, rdata_q, rd_d;
  logic            req_q, ready_q, rdy_d;

  assign c_idx = cpu_addr[IDXW-1:0];
  assign c_tag = cpu_addr[AW-1:IDXW];
  assign s_idx = snp_addr[IDXW-1:0];
  assign s_tag = snp_addr[AW-1:IDXW];
  assign c_hit = (a_st != ST_I) && (a_tag == c_tag);
  assign s_hit = (b_st != ST_I) && (b_tag == s_tag);

  // local writes win; snoops never coincide with a fill cycle
  assign arr_we  = loc_we | snp_upd;
  assign arr_idx = loc_we ? c_idx : s_idx;
  assign arr_st  = loc_we ? loc_st : snp_new_st;

  mesi_tag_state #(.LINES(LINES), .TW(TW)) u_tags (
    .clk(clk), .rst(rst),
    .a_idx(c_idx), .b_idx(s_idx),
    .we(arr_we), .w_idx(arr_idx), .w_st(arr_st),
    .tag_we(tag_we), .w_tag(c_tag),
    .a_st(a_st), .a_tag(a_tag), .b_st(b_st), .b_tag(b_tag)
  );

  mesi_data_ram #(.LINES(LINES), .DW(DW)) u_data (
    .clk(clk), .we(dat_we), .w_idx(c_idx), .w_data(dat_wd),
    .a_idx(c_idx), .a_data(a_data), .b_idx(s_idx), .b_data(b_data)
  );

  mesi_snoop_resp #(.AW(AW), .DW(DW)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .line_match(s_hit), .line_st(b_st), .line_data(b_data),
    .upd(snp_upd), .new_st(snp_new_st),
    .hit_o(snp_hit), .wb_o(snp_wb), .wb_addr_o(snp_wb_addr), .wb_data_o(snp_wb_data)
  );

  always_comb begin
    nxt_fsm    = fsm_q;
    nxt_cmd    = cmd_q;
    nxt_baddr  = baddr_q;
    nxt_bwdata = bwdata_q;
    loc_we     = 1'b0;
    loc_st     = ST_I;
    tag_we     = 1'b0;
    dat_we     = 1'b0;
    dat_wd     = cpu_wdata;
    rdy_d      = 1'b0;
    rd_d       = rdata_q;
    case (fsm_q)
      F_IDLE: begin
        if (cpu_req && !snp_valid) begin
          if (c_hit && !cpu_we) begin
            rdy_d   = 1'b1;
            rd_d    = a_data;
            nxt_fsm = F_DONE;
          end else if (c_hit && (a_st != ST_S)) begin
            loc_we  = 1'b1;
            loc_st  = ST_M;
            dat_we  = 1'b1;
            rdy_d   = 1'b1;
            rd_d    = cpu_wdata;
            nxt_fsm = F_DONE;
          end else if (c_hit) begin
            nxt_fsm   = F_REQ;
            nxt_cmd   = CMD_UPG;
            nxt_baddr = cpu_addr;
          end else if (a_st == ST_M) begin
            nxt_fsm    = F_REQ;
            nxt_cmd    = CMD_WB;
            nxt_baddr  = {a_tag, c_idx};
            nxt_bwdata = a_data;
          end else begin
            nxt_fsm   = F_REQ;
            nxt_cmd   = cpu_we ? CMD_RDX : CMD_RD;
            nxt_baddr = cpu_addr;
          end
        end
      end
      F_REQ: begin
        if (snp_valid) begin
          nxt_fsm = F_IDLE;
        end else if (bus_gnt) begin
          case (cmd_q)
            CMD_WB: begin
              loc_we  = 1'b1;
              loc_st  = ST_I;
              nxt_fsm = F_IDLE;
            end
            CMD_UPG: begin
              loc_we  = 1'b1;
              loc_st  = ST_M;
              dat_we  = 1'b1;
              rdy_d   = 1'b1;
              rd_d    = cpu_wdata;
              nxt_fsm = F_DONE;
            end
            default: nxt_fsm = F_RESP;
          endcase
        end
      end
      F_RESP: begin
        loc_we  = 1'b1;
        tag_we  = 1'b1;
        loc_st  = cpu_we ? ST_M : (bus_shared ? ST_S : ST_E);
        dat_we  = 1'b1;
        dat_wd  = cpu_we ? cpu_wdata : bus_rdata;
        rdy_d   = 1'b1;
        rd_d    = cpu_we ? cpu_wdata : bus_rdata;
        nxt_fsm = F_DONE;
      end
      default: nxt_fsm = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q    <= F_IDLE;
      cmd_q    <= CMD_NONE;
      baddr_q  <= '0;
      bwdata_q <= '0;
      req_q    <= 1'b0;
      ready_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      fsm_q    <= nxt_fsm;
      req_q    <= (nxt_fsm == F_REQ);
      cmd_q    <= (nxt_fsm == F_REQ) ? nxt_cmd : CMD_NONE;
      baddr_q  <= nxt_baddr;
      bwdata_q <= nxt_bwdata;
      ready_q  <= rdy_d;
      rdata_q  <= rd_d;
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;
  assign bus_req   = req_q;
  assign bus_cmd   = cmd_q;
  assign bus_addr  = baddr_q;
  assign bus_wdata = bwdata_q;

  // R1: no command without a request
  a_r1_idle_cmd: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> (bus_cmd == 3'd0));
  // R3: completion is a single-cycle pulse
  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R3: no request pending while a completion is reported
  a_r3_ready_no_req: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !bus_req);
  // R2: a waiting request holds its command and address
  a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_addr) && $stable(bus_cmd)));
  // R11: a snoop while waiting withdraws the request
  a_r11_snoop_withdraws: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && bus_req) |=> !bus_req);
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [2:0] C_RD = 3'd1, C_RDX = 3'd2, C_UPG = 3'd3, C_WB = 3'd4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_gnt = 1'b0, bus_shared = 1'b0;
  logic [2:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic          snp_valid = 1'b0, snp_excl = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_hit, snp_wb;
  logic [AW-1:0] snp_wb_addr;
  logic [DW-1:0] snp_wb_data;

  int checks = 0;
  int errors = 0;
  int nbus = 0;
  int cycles = 0;

  typedef struct {
    bit          is_rd;
    logic [DW-1:0] d;
    string       req;
  } exp_t;
  exp_t sb[$];

  mesi_line_ctrl u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_wb(snp_wb), .snp_wb_addr(snp_wb_addr), .snp_wb_data(snp_wb_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every completion
  always @(negedge clk) begin
    if (bus_req) nbus++;
    if (!rst && cpu_ready) begin
      if (sb.size() == 0) begin
        chk("R3 unexpected ready", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_rd) chk(e.req, cpu_rdata, e.d);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cpu_go(bit we, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] exp_rd, string req);
    exp_t e;
    e.is_rd = !we; e.d = exp_rd; e.req = req;
    sb.push_back(e);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic cpu_wait();
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic serve(logic [2:0] cmd, logic [AW-1:0] a, logic [DW-1:0] wd,
                       bit sh, logic [DW-1:0] rd, string req);
    while (!bus_req) @(negedge clk);
    chk(req, bus_cmd, cmd);
    chk(req, bus_addr, a);
    if (cmd == C_WB) chk(req, bus_wdata, wd);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    if (cmd == C_RD || cmd == C_RDX) begin
      bus_shared = sh; bus_rdata = rd;
      @(negedge clk);
      bus_shared = 1'b0;
    end
  endtask

  task automatic snoop(bit ex, logic [AW-1:0] a, bit e_hit, bit e_wb, logic [DW-1:0] e_d, string req);
    snp_valid = 1'b1; snp_excl = ex; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(req, snp_hit, e_hit);
    chk(req, snp_wb, e_wb);
    if (e_wb) begin
      chk(req, snp_wb_data, e_d);
      chk(req, snp_wb_addr, a);
    end
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", cpu_ready, 0);
    chk("R1 req", bus_req, 0);
    chk("R1 cmd", bus_cmd, 0);
    chk("R1 hit", snp_hit, 0);
    chk("R1 wb", snp_wb, 0);

    // R2: read miss with no sharer installs Exclusive
    cpu_go(0, 12'h013, 0, 32'hA1, "R2 fill"); serve(C_RD, 12'h013, 0, 0, 32'hA1, "R2"); cpu_wait();
    // R6: silent write on Exclusive
    b = nbus; cpu_go(1, 12'h013, 32'hB2, 0, "R6"); cpu_wait(); chk("R6 no bus", nbus, b);
    // R3: read hit on Modified
    b = nbus; cpu_go(0, 12'h013, 0, 32'hB2, "R3 data"); cpu_wait(); chk("R3 no bus", nbus, b);
    // R8: snooped read on Modified
    snoop(0, 12'h013, 1, 1, 32'hB2, "R8");
    b = nbus; cpu_go(0, 12'h013, 0, 32'hB2, "R3 data S"); cpu_wait(); chk("R3 no bus S", nbus, b);
    // R7: snooped read on Shared
    snoop(0, 12'h013, 1, 0, 0, "R7");
    // R5: write to Shared upgrades
    cpu_go(1, 12'h013, 32'hC3, 0, "R5"); serve(C_UPG, 12'h013, 0, 0, 0, "R5"); cpu_wait();
    // R9: read-exclusive on Modified writes back and invalidates
    snoop(1, 12'h013, 0, 1, 32'hC3, "R9");
    cpu_go(0, 12'h013, 0, 32'hD4, "R9 refill"); serve(C_RD, 12'h013, 0, 1, 32'hD4, "R9 invalid"); cpu_wait();
    snoop(1, 12'h013, 0, 0, 0, "R9 shared");
    // R2: read miss with a sharer installs Shared
    cpu_go(0, 12'h025, 0, 32'hE5, "R2 fill S"); serve(C_RD, 12'h025, 0, 1, 32'hE5, "R2 S"); cpu_wait();
    snoop(0, 12'h025, 1, 0, 0, "R2 shared state");
    // R4: write miss
    cpu_go(1, 12'h036, 32'h66, 0, "R4"); serve(C_RDX, 12'h036, 0, 0, 32'h1234, "R4"); cpu_wait();
    snoop(0, 12'h036, 1, 1, 32'h66, "R4 modified");
    // R10: dirty victim written back before the new read
    cpu_go(1, 12'h047, 32'h77, 0, "R4 b"); serve(C_RDX, 12'h047, 0, 0, 0, "R4 b"); cpu_wait();
    cpu_go(0, 12'h147, 0, 32'h99, "R10 fill");
    serve(C_WB, 12'h047, 32'h77, 0, 0, "R10 wb");
    serve(C_RD, 12'h147, 0, 0, 32'h99, "R10 rd"); cpu_wait();
    cpu_go(0, 12'h047, 0, 32'h88, "R10 clean fill"); serve(C_RD, 12'h047, 0, 0, 32'h88, "R10 clean"); cpu_wait();
    // R7: snoop misses
    snoop(0, 12'h0F0, 0, 0, 0, "R7 miss");
    snoop(1, 12'h147, 0, 0, 0, "R7 miss tag");
    // R11: snoop collides with grant of a pending upgrade
    cpu_go(1, 12'h025, 32'h55, 0, "R11");
    while (!bus_req) @(negedge clk);
    chk("R11 upg", bus_cmd, C_UPG);
    bus_gnt = 1'b1; snp_valid = 1'b1; snp_excl = 1'b1; snp_addr = 12'h025;
    @(negedge clk);
    bus_gnt = 1'b0; snp_valid = 1'b0;
    chk("R11 no wb", snp_wb, 0);
    chk("R11 dropped", bus_req, 0);
    serve(C_RDX, 12'h025, 0, 0, 32'hFF, "R11 redo"); cpu_wait();
    b = nbus; cpu_go(0, 12'h025, 0, 32'h55, "R11 readback"); cpu_wait(); chk("R11 no bus", nbus, b);
    // R12: snoop and new request in the same cycle
    b = nbus;
    cpu_go(0, 12'h047, 0, 32'h88, "R12 data");
    snp_valid = 1'b1; snp_excl = 1'b0; snp_addr = 12'h047;
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R12 hit", snp_hit, 1);
    chk("R12 deferred", cpu_ready, 0);
    cpu_wait();
    chk("R12 no bus", nbus, b);
    chk("R12 scoreboard", sb.size(), 0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule